// File: doc/BRIEF.md
# Pipelined Modular Adder/Subtractor

This block adds or subtracts two residues modulo a prime and returns the reduced result. Each operation carries its own subtract select and its own modulus. It is meant to sit inside a wide prime-field datapath, for example next to a modular multiplier in a point-arithmetic engine, where it is fed one operation per clock.

The datapath is a fixed-depth pipeline, not an iterative controller. An input register captures the operation. The first stage then forms the raw 384-bit sum or difference in one cycle. The second stage computes the candidate with the modulus subtracted (for addition) or added back (for subtraction), together with the decision flag. The third stage selects between the raw and corrected values. Each result leaves exactly four clock edges after its operands were sampled. Operations issued on consecutive cycles come out on consecutive cycles, in the same order.

The caller must supply operands that are already below the modulus.

Top module: `modarith_pipe`

## Requirements
- R1: The operand, modulus and result ports are 381 bits wide. The internal raw arithmetic is 384 bits wide, and every result has zero in bits 383 to 381 of that internal value.
- R2: With the subtract select at 0 (addition), the result is a+b when a+b is below the modulus, and a+b minus the modulus otherwise. A sum equal to the modulus gives 0.
- R3: With the subtract select at 1 (subtraction), the result is a−b when a is at least b, and a−b plus the modulus otherwise. Equal operands give 0.
- R4: An operation sampled at rising edge k has its result on the result port and out_valid high right after rising edge k+3, which is four sampling edges counting edge k.
- R5: A new operation is accepted on every cycle. Back-to-back operations with mixed subtract selects and different moduli each produce their own correct result, in issue order, on consecutive cycles.
- R6: out_valid equals in_valid delayed by exactly four cycles.
- R7: When both operands are below the modulus, every valid result is below the modulus.
- R8: While rst_n is low, out_valid is low. After release, out_valid stays low until an operation has travelled the full pipeline, and operations in flight when reset is asserted are discarded.
- R9: While no valid operation leaves the pipeline, the result port holds its last value, whatever is driven on the data inputs while in_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset. Release is synchronised internally |
| in_valid | input | 1 | An operation is present on the inputs this cycle |
| in_sub | input | 1 | 0 selects modular addition, 1 selects modular subtraction |
| in_a | input | 381 | First operand, below in_mod |
| in_b | input | 381 | Second operand, below in_mod |
| in_mod | input | 381 | Modulus for this operation |
| out_valid | output | 1 | Result port carries a new result |
| out_res | output | 381 | Reduced result |

## Verification
Most internal faults show at the ports exactly four cycles after the affected operation is issued.

- A correction decision that is stuck or inverted shows as a result that is off by exactly the modulus: either at or above the modulus, or wrapped high. The equality corner cases (a+b equal to p, a equal to b) expose it at once.
- A subtract select that falls out of step with its data shows up only when the select changes between adjacent operations, which the back-to-back walk provokes.
- A register that loads when its data is not valid corrupts the held result during bubbles.
- A missing or extra pipeline register shifts out_valid by one cycle relative to the four-cycle point.

// File: rtl/modarith_pkg.sv
package modarith_pkg;

  // Default widths for a 381-bit prime field carried on a 384-bit adder.
  localparam int unsigned FIELD_W = 381;
  localparam int unsigned ALU_W   = 384;
  localparam int unsigned PIPE_LAT = 4;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_e;

endpackage

// File: rtl/modarith_raw.sv
// Stage 1: raw wide add or subtract, borrow captured for subtraction.
module modarith_raw
  import modarith_pkg::*;
#(
  parameter int unsigned DW = FIELD_W,
  parameter int unsigned RW = ALU_W
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  op_e           op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] p_i,
  output logic          vld_o,
  output op_e           op_o,
  output logic [RW-1:0] raw_o,
  output logic          brw_o,
  output logic [DW-1:0] p_o
);

  localparam int unsigned PAD = RW + 1 - DW;

  logic [RW:0] ext_a, ext_b, raw_n;
  logic        brw_n;

  always_comb begin
    ext_a = {{PAD{1'b0}}, a_i};
    ext_b = {{PAD{1'b0}}, b_i};
    raw_n = (op_i == OP_SUB) ? (ext_a - ext_b) : (ext_a + ext_b);
    brw_n = (op_i == OP_SUB) & raw_n[RW];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) vld_o <= 1'b0;
    else         vld_o <= vld_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      op_o  <= OP_ADD;
      raw_o <= '0;
      brw_o <= 1'b0;
      p_o   <= '0;
    end else if (vld_i) begin
      op_o  <= op_i;
      raw_o <= raw_n[RW-1:0];
      brw_o <= brw_n;
      p_o   <= p_i;
    end
  end

  // An addition of two reduced operands never produces a borrow flag
  AST_ADD_NO_BORROW: assert property (@(posedge clk) disable iff (!rst_ni)
    vld_i && (op_i == OP_ADD) |=> !brw_o); // R2

endmodule

// File: rtl/modarith_corr.sv
// Stage 2: build the corrected candidate and decide whether to use it.
module modarith_corr
  import modarith_pkg::*;
#(
  parameter int unsigned DW = FIELD_W,
  parameter int unsigned RW = ALU_W
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  op_e           op_i,
  input  logic [RW-1:0] raw_i,
  input  logic          brw_i,
  input  logic [DW-1:0] p_i,
  output logic          vld_o,
  output logic          use_alt_o,
  output logic [RW-1:0] raw_o,
  output logic [RW-1:0] alt_o,
  output logic [DW-1:0] p_o
);

  localparam int unsigned PAD = RW + 1 - DW;

  logic [RW:0] p_ext, raw_ext, alt_n;
  logic        use_alt_n;

  always_comb begin
    p_ext   = {{PAD{1'b0}}, p_i};
    raw_ext = {1'b0, raw_i};
    alt_n   = (op_i == OP_SUB) ? (raw_ext + p_ext) : (raw_ext - p_ext);
    // Subtraction: correct on borrow. Addition: correct when raw - p did not borrow.
    use_alt_n = (op_i == OP_SUB) ? brw_i : ~alt_n[RW];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) vld_o <= 1'b0;
    else         vld_o <= vld_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      use_alt_o <= 1'b0;
      raw_o     <= '0;
      alt_o     <= '0;
      p_o       <= '0;
    end else if (vld_i) begin
      use_alt_o <= use_alt_n;
      raw_o     <= raw_i;
      alt_o     <= alt_n[RW-1:0];
      p_o       <= p_i;
    end
  end

  // A wrapped negative difference plus a modulus above b must carry out of the adder
  AST_SUB_WRAP_CARRY: assert property (@(posedge clk) disable iff (!rst_ni)
    vld_i && (op_i == OP_SUB) && brw_i |-> alt_n[RW]); // R3

endmodule

// File: rtl/modarith_sel.sv
// Stage 3: pick raw or corrected value and register the result.
module modarith_sel
  import modarith_pkg::*;
#(
  parameter int unsigned DW = FIELD_W,
  parameter int unsigned RW = ALU_W
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic          use_alt_i,
  input  logic [RW-1:0] raw_i,
  input  logic [RW-1:0] alt_i,
  input  logic [DW-1:0] p_i,
  output logic          vld_o,
  output logic [DW-1:0] res_o
);

  logic [RW-1:0] full_n;

  always_comb begin
    full_n = use_alt_i ? alt_i : raw_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) vld_o <= 1'b0;
    else         vld_o <= vld_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    res_o <= '0;
    else if (vld_i) res_o <= full_n[DW-1:0];
  end

  AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    vld_i |-> (full_n[RW-1:DW] == '0)); // R1

  AST_RES_BELOW_MOD: assert property (@(posedge clk) disable iff (!rst_ni)
    vld_i |-> (full_n[DW-1:0] < p_i)); // R7

endmodule

// File: rtl/modarith_pipe.sv
// Top: input register, then raw / correction / select stages (latency 4).
module modarith_pipe
  import modarith_pkg::*;
#(
  parameter int unsigned DW = FIELD_W,
  parameter int unsigned RW = ALU_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sub,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic [DW-1:0] in_mod,
  output logic          out_valid,
  output logic [DW-1:0] out_res
);

  localparam int unsigned LAT = PIPE_LAT;
  localparam int unsigned CW  = $clog2(LAT + 1);

  // Reset: asserted asynchronously, released on the second clock edge
  logic rst_meta, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ni   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ni   <= rst_meta;
    end
  end

  // Input capture register
  logic          s0_vld;
  op_e           s0_op;
  logic [DW-1:0] s0_a, s0_b, s0_p;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) s0_vld <= 1'b0;
    else         s0_vld <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_op <= OP_ADD;
      s0_a  <= '0;
      s0_b  <= '0;
      s0_p  <= '0;
    end else if (in_valid) begin
      s0_op <= op_e'(in_sub);
      s0_a  <= in_a;
      s0_b  <= in_b;
      s0_p  <= in_mod;
    end
  end

  logic          s1_vld, s1_brw;
  op_e           s1_op;
  logic [RW-1:0] s1_raw;
  logic [DW-1:0] s1_p;

  modarith_raw #(.DW(DW), .RW(RW)) u_raw (
    .clk(clk), .rst_ni(rst_ni),
    .vld_i(s0_vld), .op_i(s0_op), .a_i(s0_a), .b_i(s0_b), .p_i(s0_p),
    .vld_o(s1_vld), .op_o(s1_op), .raw_o(s1_raw), .brw_o(s1_brw), .p_o(s1_p)
  );

  logic          s2_vld, s2_use_alt;
  logic [RW-1:0] s2_raw, s2_alt;
  logic [DW-1:0] s2_p;

  modarith_corr #(.DW(DW), .RW(RW)) u_corr (
    .clk(clk), .rst_ni(rst_ni),
    .vld_i(s1_vld), .op_i(s1_op), .raw_i(s1_raw), .brw_i(s1_brw), .p_i(s1_p),
    .vld_o(s2_vld), .use_alt_o(s2_use_alt), .raw_o(s2_raw), .alt_o(s2_alt), .p_o(s2_p)
  );

  modarith_sel #(.DW(DW), .RW(RW)) u_sel (
    .clk(clk), .rst_ni(rst_ni),
    .vld_i(s2_vld), .use_alt_i(s2_use_alt), .raw_i(s2_raw), .alt_i(s2_alt), .p_i(s2_p),
    .vld_o(out_valid), .res_o(out_res)
  );

  // Cycles since internal reset release, saturating at the latency
  logic [CW-1:0] since_rst_q, since_rst_n;
  always_comb begin
    since_rst_n = since_rst_q;
    if (since_rst_q != CW'(LAT)) since_rst_n = since_rst_q + 1'b1;
  end
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) since_rst_q <= '0;
    else         since_rst_q <= since_rst_n;
  end

  AST_INPUTS_REDUCED: assert property (@(posedge clk) disable iff (!rst_ni)
    in_valid |-> (in_a < in_mod) && (in_b < in_mod)); // R7

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_ni)
    (since_rst_q == CW'(LAT)) |-> (out_valid == $past(in_valid, 4))); // R6

  AST_EARLY_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
    (since_rst_q < CW'(LAT)) |-> !out_valid); // R8

endmodule

// File: tb/tb_modarith_pipe.sv
module tb_modarith_pipe;

  localparam int unsigned DW = 381;
  localparam logic [DW-1:0] PB =
    381'h1a0111ea397fe69a4b1ba7b6434bacd764774b84f38512bf6730d2a0f6b0f6241eabfffeb153ffffb9feffffffffaaab;
  localparam logic [DW-1:0] P97 = 381'd97;
  localparam logic [DW-1:0] H   = 381'd1 << 380;

  typedef struct packed {
    logic          sub;
    logic [DW-1:0] a;
    logic [DW-1:0] b;
    logic [DW-1:0] p;
  } vec_t;

  localparam int N = 12;
  localparam vec_t VEC [N] = '{
    '{1'b0, 381'd5,  381'd7,  P97},  // R2 plain add
    '{1'b0, 381'd50, 381'd47, P97},  // R2 sum equals p
    '{1'b0, 381'd96, 381'd96, P97},  // R2 max operands
    '{1'b1, 381'd10, 381'd3,  P97},  // R3 no borrow
    '{1'b1, 381'd3,  381'd10, P97},  // R3 borrow
    '{1'b1, 381'd42, 381'd42, P97},  // R3 equal
    '{1'b1, 381'd0,  381'd96, P97},  // R3 extreme borrow
    '{1'b0, PB - 1,  PB - 1,  PB},   // R1 wide add
    '{1'b1, 381'd0,  PB - 1,  PB},   // R1 wide sub
    '{1'b0, PB - 1,  381'd1,  PB},   // R2 wide sum equals p
    '{1'b0, H,       H,       PB},   // R1 carry into bit 381
    '{1'b1, 381'd1,  H,       PB}    // R3 wide borrow
  };

  logic          clk, rst_n, in_valid, in_sub, out_valid;
  logic [DW-1:0] in_a, in_b, in_mod, out_res;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  modarith_pipe dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sub(in_sub),
    .in_a(in_a), .in_b(in_b), .in_mod(in_mod),
    .out_valid(out_valid), .out_res(out_res)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [DW-1:0] model(logic sub, logic [DW-1:0] a, logic [DW-1:0] b,
                                           logic [DW-1:0] p);
    logic [DW:0] s;
    if (!sub) begin
      s = {1'b0, a} + {1'b0, b};
      if (s >= {1'b0, p}) s = s - {1'b0, p};
    end else if (a >= b) begin
      s = {1'b0, a} - {1'b0, b};
    end else begin
      s = {1'b0, a} + {1'b0, p} - {1'b0, b};
    end
    return s[DW-1:0];
  endfunction

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(logic v, logic s, logic [DW-1:0] a, logic [DW-1:0] b, logic [DW-1:0] p);
    in_valid = v; in_sub = s; in_a = a; in_b = b; in_mod = p;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive(1'b0, 1'b0, '0, '0, P97);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [DW-1:0] held;
    do_reset();
    // R8: reset state
    chk(out_valid == 1'b0, "R8 valid low after reset", DW'(out_valid), '0);
    chk(out_res == '0, "R8 result cleared", out_res, '0);

    // R5/R2/R3/R1: back-to-back walk of the table, mixed selects and moduli
    for (int i = 0; i < N + 4; i++) begin
      if (i >= 4) begin
        chk(out_valid == 1'b1, "R5 valid in stream", DW'(out_valid), 1);
        chk(out_res == model(VEC[i-4].sub, VEC[i-4].a, VEC[i-4].b, VEC[i-4].p),
            VEC[i-4].sub ? "R3 sub result" : "R2 add result", out_res,
            model(VEC[i-4].sub, VEC[i-4].a, VEC[i-4].b, VEC[i-4].p));
      end
      if (i < N) drive(1'b1, VEC[i].sub, VEC[i].a, VEC[i].b, VEC[i].p);
      else       drive(1'b0, 1'b0, '0, '0, P97);
      @(negedge clk);
    end

    // R4/R6: single operation, valid appears on the fourth edge exactly
    drive(1'b1, 1'b1, 381'd20, 381'd30, P97);
    @(negedge clk);
    drive(1'b0, 1'b0, 381'd1, 381'd2, P97);
    for (int k = 1; k < 4; k++) begin
      chk(out_valid == 1'b0, "R6 valid not early", DW'(out_valid), 0);
      @(negedge clk);
    end
    chk(out_valid == 1'b1, "R4 valid at latency", DW'(out_valid), 1);
    chk(out_res == 381'd87, "R4 result at latency", out_res, 381'd87);
    held = out_res;

    // R9: bubbles with garbage data keep the result
    for (int k = 0; k < 6; k++) begin
      drive(1'b0, k[0], 381'd90 - DW'(k), 381'd11 + DW'(k), PB);
      @(negedge clk);
      chk(out_valid == 1'b0, "R6 valid low in bubble", DW'(out_valid), 0);
      chk(out_res == held, "R9 result held", out_res, held);
    end

    // R8: reset with operations in flight
    for (int k = 0; k < 3; k++) begin
      drive(1'b1, 1'b0, 381'd4, DW'(k), P97);
      @(negedge clk);
    end
    drive(1'b0, 1'b0, '0, '0, P97);
    rst_n = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R8 valid drops in reset", DW'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R8 flushed ops dropped", DW'(out_valid), 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule